// File: doc/BRIEF.md
# Serial-bus wiper register slave

This block is a two-wire serial-bus slave that owns one volatile wiper position register, the value that sets the tap of a digitally controlled resistor divider. It oversamples the clock and data lines on the system clock. Each line passes through a two-flop synchronizer and a short majority filter, so narrow glitches never reach the protocol logic. It then finds START and STOP conditions and bit edges in the filtered lines. It drives the data line only through an active-low enable, which the pad turns into an open-drain pull-down.

A transfer begins with a START and an identification byte. The upper five bits of that byte are a fixed prefix, the next two bits come from two strap pins, and the last bit gives the direction. A write continues with a register address byte and a data byte, and the slave acknowledges each byte. A read returns the register as a single byte right after the identification acknowledge, with no address phase. The register output feeds the resistor array directly, and a one-cycle strobe marks every accepted update.

Top module: `wiper_i2c_slave`

## Requirements
- R1: The identification byte is acknowledged only when its seven upper bits equal 01010 followed by strap_i[1] and strap_i[0]. The acknowledge is sda_oe_o = 1 (SDA low) during the ninth clock. A mismatching byte is not acknowledged, and the slave then stays released for the rest of the transfer.
- R2: A write is START, identification byte with bit 0 = 0, register address 0x00, data byte, STOP. Each of the three bytes is acknowledged, and wiper_o then holds the data byte's low seven bits. Every byte moves MSB first.
- R3: Bit 7 of a written data byte is discarded. A read returns bit 7 as 0.
- R4: An identification byte with bit 0 = 1 is acknowledged, and then the eight bits {0, wiper_o} follow, MSB first. Each bit is driven after an SCL falling edge and holds while SCL is high.
- R5: A register address byte other than 0x00 is not acknowledged. The data byte that follows is neither acknowledged nor stored.
- R6: After reset wiper_o is 64 (0x40), sda_oe_o is 0 and wiper_upd_o is 0.
- R7: wiper_upd_o is a single-cycle pulse. It fires exactly once per accepted write, at the SCL falling edge that ends the data-byte acknowledge. wiper_o changes only in that cycle.
- R8: Bus activity before a START is ignored. A STOP or START in the middle of a transfer abandons it without changing wiper_o, and a START restarts identification matching.
- R9: A pulse on SCL or SDA that lasts one system clock is suppressed and does not count as a bit edge.
- R10: sda_oe_o changes only while the filtered SCL is low. It is released at the end of every acknowledge and after the eighth transmitted bit, so the master's acknowledge bit after a read sees SDA high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 2 | Strap pins giving the two low address bits (bit 1 is sent first) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_o | output | 7 | Wiper position register |
| wiper_upd_o | output | 1 | One-cycle pulse when a write updates the register |

## Verification
A table of transactions covers the address checks. It mixes matching identifications, a strap-bit mismatch, a prefix mismatch and a non-zero register address. Together these show that the prefix, the strap bits and the register address are each compared on their own. The write data patterns include one with bit 7 set and one with alternating bits, so a lost MSB, a dropped bit or a bit-order error shows up in the read-back byte. Directed sequences then cover the other cases. A STOP or a repeated START partway through a data byte must leave the register untouched. A byte clocked with no START must be ignored. A one-cycle SCL glitch must not add a bit. After the strap pins change, the old address must be refused and the new one accepted.

// File: rtl/wiper_i2c_pkg.sv
package wiper_i2c_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_ACK_WR,
    ST_ACK_RD,
    ST_REG,
    ST_ACK_REG,
    ST_DATA,
    ST_ACK_DAT,
    ST_TX,
    ST_WAIT
  } bus_st_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int HALF  = FILT_LEN / 2;
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic                s1_q, s2_q;
  logic [FILT_LEN-1:0] win_q, win_d;
  logic                out_q, out_d;
  logic [CNT_W-1:0]    ones;

  always_comb begin
    win_d = {win_q[FILT_LEN-2:0], s2_q};
    ones  = '0;
    for (int i = 0; i < FILT_LEN; i++) begin
      ones = ones + CNT_W'(win_q[i]);
    end
    out_d = (ones > CNT_W'(HALF));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      win_q <= '1;
      out_q <= 1'b1;
    end else begin
      s1_q  <= line_i;
      s2_q  <= s1_q;
      win_q <= win_d;
      out_q <= out_d;
    end
  end

  assign line_o = out_q;

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
    end
  end

  assign scl_rise_o = scl_f_i & ~scl_q;
  assign scl_fall_o = ~scl_f_i & scl_q;
  assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;

endmodule

// File: rtl/wiper_i2c_fsm.sv
module wiper_i2c_fsm
  import wiper_i2c_pkg::*;
#(
  parameter int          WIPER_W   = 7,
  parameter int          RESET_VAL = 64,
  parameter int          STRAP_W   = 2,
  parameter logic [4:0]  PREFIX    = 5'b01010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               upd_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BYTE_W - 1);

  bus_st_e             st_q, st_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [BYTE_W-1:0]   sh_q, sh_d;
  logic                full_q, full_d;
  logic                oe_q, oe_d;
  logic [WIPER_W-1:0]  wip_q, wip_d;
  logic                wip_en;
  logic                upd_q;
  logic                id_match;
  logic [BYTE_W-1:0]   tx_byte;

  assign id_match = (sh_q[BYTE_W-1:1] == {PREFIX, strap_i});
  assign tx_byte  = BYTE_W'(wip_q);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    full_d = full_q;
    oe_d   = oe_q;
    wip_d  = wip_q;
    wip_en = 1'b0;
    if (stop_i) begin
      st_d   = ST_IDLE;
      oe_d   = 1'b0;
      full_d = 1'b0;
      cnt_d  = '0;
    end else if (start_i) begin
      st_d   = ST_ID;
      oe_d   = 1'b0;
      full_d = 1'b0;
      cnt_d  = '0;
    end else begin
      case (st_q)
        ST_ID, ST_REG, ST_DATA: begin
          if (scl_rise_i && !full_q) begin
            sh_d = {sh_q[BYTE_W-2:0], sda_i};
            if (cnt_q == CNT_MAX) full_d = 1'b1;
            else                  cnt_d  = cnt_q + 1'b1;
          end else if (scl_fall_i && full_q) begin
            full_d = 1'b0;
            cnt_d  = '0;
            if (st_q == ST_ID) begin
              if (id_match) begin
                oe_d = 1'b1;
                st_d = sh_q[0] ? ST_ACK_RD : ST_ACK_WR;
              end else begin
                st_d = ST_IDLE;
              end
            end else if (st_q == ST_REG) begin
              if (sh_q == '0) begin
                oe_d = 1'b1;
                st_d = ST_ACK_REG;
              end else begin
                st_d = ST_WAIT;
              end
            end else begin
              oe_d = 1'b1;
              st_d = ST_ACK_DAT;
            end
          end
        end
        ST_ACK_WR: begin
          if (scl_fall_i) begin
            oe_d = 1'b0;
            st_d = ST_REG;
          end
        end
        ST_ACK_REG: begin
          if (scl_fall_i) begin
            oe_d = 1'b0;
            st_d = ST_DATA;
          end
        end
        ST_ACK_DAT: begin
          if (scl_fall_i) begin
            oe_d   = 1'b0;
            wip_d  = sh_q[WIPER_W-1:0];
            wip_en = 1'b1;
            st_d   = ST_WAIT;
          end
        end
        ST_ACK_RD: begin
          if (scl_fall_i) begin
            sh_d  = tx_byte;
            oe_d  = ~tx_byte[BYTE_W-1];
            cnt_d = '0;
            st_d  = ST_TX;
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == CNT_MAX) begin
              oe_d = 1'b0;
              st_d = ST_WAIT;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      full_q <= 1'b0;
      oe_q   <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      full_q <= full_d;
      oe_q   <= oe_d;
      upd_q  <= wip_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip_q <= WIPER_W'(RESET_VAL);
    end else if (wip_en) begin
      wip_q <= wip_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign wiper_o  = wip_q;
  assign upd_o    = upd_q;

endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
  parameter int         WIPER_W   = 7,
  parameter int         RESET_VAL = 64,
  parameter int         STRAP_W   = 2,
  parameter logic [4:0] PREFIX    = 5'b01010,
  parameter int         FILT_LEN  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               wiper_upd_o
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] flt_lines;
  logic               scl_flt, sda_flt;
  logic               scl_rise, scl_fall, bus_start, bus_stop;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (flt_lines[g])
    );
  end

  assign scl_flt = flt_lines[0];
  assign sda_flt = flt_lines[1];

  i2c_bus_events u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f_i    (scl_flt),
    .sda_f_i    (sda_flt),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  wiper_i2c_fsm #(
    .WIPER_W   (WIPER_W),
    .RESET_VAL (RESET_VAL),
    .STRAP_W   (STRAP_W),
    .PREFIX    (PREFIX)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_i      (sda_flt),
    .strap_i    (strap_i),
    .sda_oe_o   (sda_oe_o),
    .wiper_o    (wiper_o),
    .upd_o      (wiper_upd_o)
  );

endmodule

// File: rtl/wiper_i2c_chk.sv
module wiper_i2c_chk #(
  parameter int WIPER_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_f,
  input logic               sda_oe,
  input logic [WIPER_W-1:0] wiper,
  input logic               upd
);

  // R7
  upd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  // R7
  wiper_change_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper) |-> upd);

  // R10
  oe_stable_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  // R10
  ack_release_on_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (!sda_oe && $past(sda_oe)));

endmodule

bind wiper_i2c_slave wiper_i2c_chk #(.WIPER_W(WIPER_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_f  (scl_flt),
  .sda_oe (sda_oe_o),
  .wiper  (wiper_o),
  .upd    (wiper_upd_o)
);

// File: tb/wiper_i2c_slave_tb.sv
module wiper_i2c_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic       sda_oe;
  logic [6:0] wiper;
  logic       upd;
  logic       sda_bus;

  int n_chk = 0;
  int n_fail = 0;
  int upd_cnt = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_i2c_slave u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .strap_i     (strap),
    .sda_oe_o    (sda_oe),
    .wiper_o     (wiper),
    .wiper_upd_o (upd)
  );

  always @(posedge clk) if (upd) upd_cnt <= upd_cnt + 1;

  typedef struct packed {
    logic       rd;
    logic [6:0] id;
    logic [7:0] ra;
    logic [7:0] dat;
    logic       id_ack;
    logic       ra_ack;
    logic [6:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'h2A, 8'h00, 8'h15, 1'b1, 1'b1, 7'h15},
    '{1'b1, 7'h2A, 8'h00, 8'h00, 1'b1, 1'b0, 7'h15},
    '{1'b0, 7'h2A, 8'h00, 8'h9A, 1'b1, 1'b1, 7'h1A},
    '{1'b1, 7'h2A, 8'h00, 8'h00, 1'b1, 1'b0, 7'h1A},
    '{1'b0, 7'h2B, 8'h00, 8'h55, 1'b0, 1'b0, 7'h1A},
    '{1'b0, 7'h6A, 8'h00, 8'h55, 1'b0, 1'b0, 7'h1A},
    '{1'b0, 7'h2A, 8'h01, 8'h55, 1'b1, 1'b0, 7'h1A},
    '{1'b1, 7'h29, 8'h00, 8'h00, 1'b0, 1'b0, 7'h1A},
    '{1'b0, 7'h2A, 8'h00, 8'h00, 1'b1, 1'b1, 7'h00},
    '{1'b1, 7'h2A, 8'h00, 8'h00, 1'b1, 1'b0, 7'h00}
  };

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(2*Q);
    sda_m = 1'b0; wt(2*Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(2*Q);
    sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic send_bit(input logic b);
    wt(Q); sda_m = b; wt(Q);
    scl_m = 1'b1; wt(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    wt(Q); sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    @(negedge clk) b = sda_bus;
    wt(Q);
    scl_m = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    send_bits(v, 8);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, output logic released);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    recv_bit(b);
    released = b;
  endtask

  task automatic do_write(input logic [6:0] id, input logic [7:0] ra, input logic [7:0] d,
                          output logic a0, output logic a1, output logic a2);
    bus_start();
    send_byte({id, 1'b0}, a0);
    send_byte(ra, a1);
    send_byte(d, a2);
    bus_stop();
    wt(Q);
  endtask

  task automatic do_read(input logic [6:0] id, output logic a0, output logic [7:0] d,
                         output logic rel);
    bus_start();
    send_byte({id, 1'b1}, a0);
    recv_byte(d, rel);
    bus_stop();
    wt(Q);
  endtask

  initial begin
    logic a0, a1, a2, rel;
    logic [7:0] d;
    int u0;

    wt(5);
    @(negedge clk);
    // R6 reset state
    chk("R6 wiper reset", int'(wiper), 'h40);
    chk("R6 oe reset", int'(sda_oe), 0);
    chk("R6 upd reset", int'(upd), 0);
    rst_n = 1'b1;
    wt(20);
    do_read(7'h2A, a0, d, rel);
    chk("R6 read of reset value", int'(d), 'h40);

    for (int v = 0; v < NV; v++) begin
      u0 = upd_cnt;
      if (!VECS[v].rd) begin
        do_write(VECS[v].id, VECS[v].ra, VECS[v].dat, a0, a1, a2);
        chk("R1 id ack", int'(a0), int'(VECS[v].id_ack));
        chk("R5 reg addr ack", int'(a1), int'(VECS[v].ra_ack));
        chk("R2 data ack", int'(a2), int'(VECS[v].ra_ack));
        chk("R2 wiper after write", int'(wiper), int'(VECS[v].exp));
        chk("R7 update pulses", upd_cnt - u0, VECS[v].ra_ack ? 1 : 0);
      end else begin
        do_read(VECS[v].id, a0, d, rel);
        chk("R1 read id ack", int'(a0), int'(VECS[v].id_ack));
        chk("R4 read data", int'(d), VECS[v].id_ack ? int'({1'b0, VECS[v].exp}) : 'hFF);
        chk("R10 released at master ack bit", int'(rel), 1);
        chk("R7 no update on read", upd_cnt - u0, 0);
      end
      chk("R10 oe idle after stop", int'(sda_oe), 0);
    end

    // R3 bit 7 discarded, read back as 0
    do_write(7'h2A, 8'h00, 8'hC5, a0, a1, a2);
    do_read(7'h2A, a0, d, rel);
    chk("R3 msb dropped on readback", int'(d), 'h45);

    // R9 one-cycle SCL glitch during data byte
    bus_start();
    send_byte(8'h54, a0);
    send_byte(8'h00, a1);
    wt(Q/2);
    scl_m = 1'b1; wt(1); scl_m = 1'b0;
    send_byte(8'h33, a2);
    bus_stop();
    wt(Q);
    chk("R9 glitch ignored ack", int'(a2), 1);
    chk("R9 glitch ignored data", int'(wiper), 'h33);

    // R8 STOP mid data byte aborts
    u0 = upd_cnt;
    bus_start();
    send_byte(8'h54, a0);
    send_byte(8'h00, a1);
    send_bits(8'h11, 4);
    bus_stop();
    wt(Q);
    chk("R8 stop abort keeps wiper", int'(wiper), 'h33);
    chk("R8 stop abort no update", upd_cnt - u0, 0);

    // R8 repeated START mid data byte restarts matching
    bus_start();
    send_byte(8'h54, a0);
    send_byte(8'h00, a1);
    send_bits(8'h7E, 3);
    chk("R8 no change before restart", int'(wiper), 'h33);
    do_write(7'h2A, 8'h00, 8'h22, a0, a1, a2);
    chk("R8 restart write ack", int'(a0 & a1 & a2), 1);
    chk("R8 restart write data", int'(wiper), 'h22);

    // R8 bytes with no START are ignored
    u0 = upd_cnt;
    wt(Q); scl_m = 1'b0;
    send_byte(8'h54, a0);
    send_byte(8'h00, a1);
    send_byte(8'h07, a2);
    bus_stop();
    wt(Q);
    chk("R8 no start no ack", int'(a0 | a1 | a2), 0);
    chk("R8 no start wiper kept", int'(wiper), 'h22);
    chk("R8 no start no update", upd_cnt - u0, 0);

    // R1 strap pins select the low address bits
    strap = 2'b01;
    wt(Q);
    do_write(7'h2A, 8'h00, 8'h0B, a0, a1, a2);
    chk("R1 old address refused", int'(a0), 0);
    chk("R1 old address wiper kept", int'(wiper), 'h22);
    do_write(7'h29, 8'h00, 8'h0A, a0, a1, a2);
    chk("R1 new address ack", int'(a0), 1);
    chk("R1 new address write", int'(wiper), 'h0A);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule